// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block freezes the frequency-select straps of a clock generator at power-up. Five select straps and an active-low power-good line come in asynchronously. The block synchronizes them and waits until power-good has been seen low twice in a row. At that point it latches the straps into a code that the downstream clock-generation logic reads. After the capture it ignores any further movement on power-good or on the straps.

A separate strap has already been digitized into a "high level" flag by an external comparator. If that flag is set when the capture happens, the block enters test mode. In test mode the lock is bypassed, so the latched code keeps following the synchronized straps. The B strap then chooses what every clock output does: either all outputs are tristated, or all of them drive the reference clock divided down.

Outside test mode, a small write port sets one enable bit per output. Each bit comes out of reset set to 1, so software does not have to program anything. A cleared bit forces its output to tristate.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `fs_code` is 0, `locked` and `test_mode` are 0, every enable bit reads back 1 and every output mode is DRIVE (code 0).
- R2: `pwrgd_n`, `fs_strap` and `c_high` each pass through two flops. A capture happens on the third rising edge after the first edge that samples `pwrgd_n` low, provided `pwrgd_n` is still low at the second edge. A low pulse seen at only one edge never causes a capture.
- R3: The captured `fs_code` equals the strap values sampled two edges before the capture edge, with bit 0 = strap A, bit 1 = strap B, bit 2 = strap C and bit 4 = strap E.
- R4: Once locked outside test mode, `fs_code` no longer changes, whatever `fs_strap` and `pwrgd_n` do, until reset.
- R5: `locked` goes to 1 on the capture edge and stays at 1 until reset.
- R6: `test_mode` goes to 1 on the capture edge only if the synchronized `c_high` is 1 at that edge. From then on, `fs_code` follows `fs_strap` with two cycles of latency.
- R7: In test mode, every output mode is REFDIV (code 2) when `fs_code[1]` is 1 and TRISTATE (code 1) when it is 0, whatever the enable bits hold.
- R8: Outside test mode, output i has mode DRIVE (0) when its enable bit is 1 and TRISTATE (1) when it is 0. It never has mode REFDIV.
- R9: A cycle with `wr_en` high writes `wr_data` into enable bit `wr_addr`, effective from the next edge. `rd_data` shows enable bit `rd_addr` without delay. A write to an address of `NUM_OUT` or above changes no bit, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Asynchronous power-good, active low |
| fs_strap | input | 5 | Asynchronous select straps, bit 0 = A to bit 4 = E |
| c_high | input | 1 | Pre-digitized flag: strap C above its mid threshold |
| wr_en | input | 1 | Enable-bit write strobe |
| wr_addr | input | ADDR_W | Output index to write |
| wr_data | input | 1 | Enable value to write |
| rd_addr | input | ADDR_W | Output index to read |
| rd_data | output | 1 | Enable bit at `rd_addr` |
| fs_code | output | 5 | Latched select code |
| locked | output | 1 | Capture has happened |
| test_mode | output | 1 | Test mode is active |
| out_mode | output | 2*NUM_OUT | Per-output mode, 2 bits each: 0 drive, 1 tristate, 2 divided reference |

## Verification
The capture path is tried with three kinds of power-good stimulus: a single-cycle low glitch, which must not lock; a clean low while the straps hold one pattern; and strap and power-good toggling after the lock, which must leave the code frozen. A second run after reset raises the C-high flag and then walks strap B both ways. This separates test-mode tracking and the tristate/divided-reference choice from the normal path. The enable bits are written in range and out of range, and each is read back before and after the lock. This shows that the bits matter only outside test mode.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int FS_W     = 5;
    localparam int FS_B_IDX = 1;

    typedef enum logic [1:0] {
        OM_DRIVE    = 2'd0,
        OM_TRISTATE = 2'd1,
        OM_REFDIV   = 2'd2
    } out_mode_e;

    typedef struct packed {
        logic            pg_n;
        logic            c_high;
        logic [FS_W-1:0] fs;
    } strap_in_t;

    localparam int STRAP_W = $bits(strap_in_t);
    localparam strap_in_t STRAP_IDLE = '{pg_n: 1'b1, c_high: 1'b0, fs: '0};

    function automatic out_mode_e pick_mode(input logic test, input logic b_lvl,
                                            input logic en);
        if (test)
            return b_lvl ? OM_REFDIV : OM_TRISTATE;
        return en ? OM_DRIVE : OM_TRISTATE;
    endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  strap_in_t       s,
    output logic [FS_W-1:0] code,
    output logic            locked,
    output logic            test_mode
);
    logic pg_prev;
    logic valid_lo;

    always_ff @(posedge clk) begin
        if (rst) pg_prev <= 1'b1;
        else     pg_prev <= s.pg_n;
    end

    assign valid_lo = !s.pg_n && !pg_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            code      <= '0;
            locked    <= 1'b0;
            test_mode <= 1'b0;
        end else if (!locked && valid_lo) begin
            code      <= s.fs;
            locked    <= 1'b1;
            test_mode <= s.c_high;
        end else if (test_mode) begin
            code      <= s.fs;
        end
    end
endmodule

// File: rtl/strap_enable_regs.sv
module strap_enable_regs #(
    parameter int NUM_OUT = 6,
    parameter int AW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic               wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic               rd_data,
    output logic [NUM_OUT-1:0] en
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                en[i] <= 1'b1;
            else if (wr_en && wr_addr == AW'(i))
                en[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 1'b0;
        for (int i = 0; i < NUM_OUT; i++)
            if (rd_addr == AW'(i)) rd_data = en[i];
    end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwrgd_n,
    input  logic [4:0]           fs_strap,
    input  logic                 c_high,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_data,
    output logic [4:0]           fs_code,
    output logic                 locked,
    output logic                 test_mode,
    output logic [2*NUM_OUT-1:0] out_mode
);
    localparam int MODE_W = $bits(out_mode_e);

    strap_in_t          raw_in;
    strap_in_t          sync_in;
    logic [NUM_OUT-1:0] en;

    assign raw_in = '{pg_n: pwrgd_n, c_high: c_high, fs: fs_strap};

    strap_sync #(.W(STRAP_W), .RST_VAL(STRAP_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    strap_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .s         (sync_in),
        .code      (fs_code),
        .locked    (locked),
        .test_mode (test_mode)
    );

    strap_enable_regs #(.NUM_OUT(NUM_OUT), .AW(ADDR_W)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en      (en)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_mode
        assign out_mode[MODE_W*i +: MODE_W] = pick_mode(test_mode, fs_code[FS_B_IDX], en[i]);
    end
endmodule

// File: rtl/strap_latch_checker.sv
module strap_latch_checker #(
    parameter int NUM_OUT = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [4:0]           fs_code,
    input logic                 locked,
    input logic                 test_mode,
    input logic [2*NUM_OUT-1:0] out_mode
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!locked && !test_mode && fs_code == 5'd0));

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    assert_code_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (locked && !test_mode) |=> $stable(fs_code));

    assert_test_at_capture_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode) |-> $rose(locked));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        assert_test_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
            test_mode |-> (out_mode[2*i +: 2] != 2'd0));
        assert_normal_no_refdiv_R8: assert property (@(posedge clk) disable iff (rst)
            !test_mode |-> (out_mode[2*i +: 2] != 2'd2));
    end
endmodule

bind strap_latch_ctrl strap_latch_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fs_code   (fs_code),
    .locked    (locked),
    .test_mode (test_mode),
    .out_mode  (out_mode)
);

// File: tb/test_strap_latch_ctrl.sv
module test_strap_latch_ctrl;
    localparam int NOUT = 6;
    localparam int AW   = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pwrgd_n = 1'b1;
    logic [4:0]      fs_strap = 5'd0;
    logic            c_high = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic            wr_data = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic            rd_data;
    logic [4:0]      fs_code;
    logic            locked;
    logic            test_mode;
    logic [2*NOUT-1:0] out_mode;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    strap_latch_ctrl #(.NUM_OUT(NOUT), .ADDR_W(AW)) i_strap_latch_ctrl (
        .clk, .rst, .pwrgd_n, .fs_strap, .c_high, .wr_en, .wr_addr, .wr_data,
        .rd_addr, .rd_data, .fs_code, .locked, .test_mode, .out_mode
    );

    // Reference model: input history queues and latched state
    logic       pg_hist[$];
    logic [5:0] st_hist[$];
    logic [4:0] m_code;
    logic       m_lock, m_test;
    logic       m_en[NOUT];

    task automatic model_reset();
        pg_hist = '{1'b1, 1'b1, 1'b1};
        st_hist = '{6'd0, 6'd0};
        m_code = 5'd0; m_lock = 1'b0; m_test = 1'b0;
        for (int i = 0; i < NOUT; i++) m_en[i] = 1'b1;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            // pg_hist[1] = synced now, pg_hist[2] = synced one edge earlier
            if (!m_lock && !pg_hist[1] && !pg_hist[2]) begin
                m_code = st_hist[1][4:0];
                m_lock = 1'b1;
                m_test = st_hist[1][5];
            end else if (m_test) begin
                m_code = st_hist[1][4:0];
            end
            if (wr_en && int'(wr_addr) < NOUT) m_en[int'(wr_addr)] = wr_data;
            pg_hist.push_front(pwrgd_n);
            void'(pg_hist.pop_back());
            st_hist.push_front({c_high, fs_strap});
            void'(st_hist.pop_back());
        end
    end

    function automatic logic [2*NOUT-1:0] exp_modes();
        logic [2*NOUT-1:0] v;
        for (int i = 0; i < NOUT; i++) begin
            if (m_test) v[2*i +: 2] = m_code[1] ? 2'd2 : 2'd1;
            else        v[2*i +: 2] = m_en[i] ? 2'd0 : 2'd1;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3/R4/R6 fs_code", 32'(fs_code), 32'(m_code));
            chk("R2/R5 locked", 32'(locked), 32'(m_lock));
            chk("R6 test_mode", 32'(test_mode), 32'(m_test));
            chk("R7/R8 out_mode", 32'(out_mode), 32'(exp_modes()));
            chk("R9 rd_data", 32'(rd_data),
                32'((int'(rd_addr) < NOUT) ? m_en[int'(rd_addr)] : 1'b0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input logic d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; pwrgd_n = 1'b1; fs_strap = 5'd0; c_high = 1'b0;
        cyc(3);
        @(negedge clk);
        chk("R1 reset code", 32'(fs_code), 32'd0);
        chk("R1 reset locked", 32'(locked), 32'd0);
        chk("R1 reset test", 32'(test_mode), 32'd0);
        chk("R1 reset modes", 32'(out_mode), 32'd0);
        rst = 1'b0;
        cyc(1);
        for (int i = 0; i < NOUT; i++) begin
            rd_addr = AW'(i);
            #1;
            chk("R1 enable default", 32'(rd_data), 32'd1);
            cyc(1);
        end
    endtask

    initial begin
        do_reset();
        // R9: in-range and out-of-range writes, read back
        wr(2, 1'b0);
        wr(5, 1'b0);
        wr(7, 1'b0);
        wr(6, 1'b0);
        for (int i = 0; i < 8; i++) begin rd_addr = AW'(i); cyc(1); end
        wr(5, 1'b1);
        rd_addr = 3'd5; cyc(2);
        chk("R8 disabled out 2 tristate", 32'(out_mode[5:4]), 32'd1);
        // R2: single-cycle glitch must not lock
        fs_strap = 5'b01101;
        pwrgd_n = 1'b0; cyc(1); pwrgd_n = 1'b1;
        cyc(6);
        chk("R2 glitch no lock", 32'(locked), 32'd0);
        // R3: clean capture
        fs_strap = 5'b10110;
        pwrgd_n = 1'b0;
        cyc(6);
        chk("R3 captured code", 32'(fs_code), 32'b10110);
        chk("R5 locked after capture", 32'(locked), 32'd1);
        // R4: later changes ignored
        fs_strap = 5'b00001; pwrgd_n = 1'b1; cyc(4);
        pwrgd_n = 1'b0; fs_strap = 5'b11111; cyc(5);
        chk("R4 code frozen", 32'(fs_code), 32'b10110);
        wr(0, 1'b0); cyc(2);
        // Test mode run
        do_reset();
        wr(1, 1'b0);
        c_high = 1'b1; fs_strap = 5'b00100; pwrgd_n = 1'b0;
        cyc(6);
        chk("R6 test mode entered", 32'(test_mode), 32'd1);
        chk("R7 tristate with B low", 32'(out_mode), 32'h555);
        c_high = 1'b0; fs_strap = 5'b00110; cyc(4);
        chk("R7 refdiv with B high", 32'(out_mode), 32'hAAA);
        chk("R6 code tracks", 32'(fs_code), 32'b00110);
        fs_strap = 5'b11001; pwrgd_n = 1'b1; cyc(4);
        fs_strap = 5'b00000; cyc(4);
        do_reset();
        cyc(3);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule